// File: doc/BRIEF.md
# Instruction-Decoded Boundary Register for an Eight-Bit Device

This block is the boundary register and test-data path of an eight-bit registered device. It holds eight input cells and eight output cells, and each cell has a shift stage clocked on the rising test clock and a shadow stage clocked on the falling test clock. An instruction code from an external instruction register picks which data register sits between TDI and TDO. The choices are a one-bit bypass bit, the sixteen-cell boundary register, or a three-bit control register. The same code sets what each register loads in Capture-DR, whether the output pins are enabled, and whether the core and pins connect straight through or through the shadow stages.

The TAP controller is outside the block. It supplies one strobe per relevant controller state (capture, shift, update, Run-Test/Idle), and each strobe is held for the whole test-clock period of that state. Besides plain bypass, the block provides the following instructions:
- an output-float instruction;
- a clamp instruction that drives the pins from the cells;
- a read-back instruction whose capture changes nothing;
- a self-test instruction that captures the inverse of every cell;
- an output-toggle mode that runs while the controller sits in Run-Test/Idle;
- a control-register scan.

Top module: `scan_boundary_unit`

## Requirements
- R1: Codes 4'hF (bypass), 4'h6 (float), 4'h7 (clamp), 4'hA (toggle) and every unlisted code put the one-bit bypass register in the scan path, and that bit loads 0 in Capture-DR.
- R2: Under code 4'h6, pin_oe is 0, core_in follows pin_in, and pin_out follows core_out.
- R3: Under code 4'h7, core_in shows the input shadow stages and pin_out shows the output shadow stages, with pin_oe at 1.
- R4: Code 4'h8 puts the boundary register in the scan path. Capture-DR leaves the register unchanged, and the device stays in normal mode.
- R5: Code 4'h9 puts the boundary register in the scan path. In Capture-DR all sixteen shift stages load their own inverse, and the device stays in normal mode.
- R6: Under code 4'hA with the Run-Test/Idle strobe high, the output-cell shift stages invert on each rising tck edge, and the output shadow stages load them on each falling edge. pin_out shows those shadow stages.
- R7: Under code 4'hA, the input cells hold their contents, take nothing from pin_in, and keep driving core_in.
- R8: Code 4'hB puts the three-bit control register in the scan path. Capture-DR leaves it unchanged, and the device stays in normal mode.
- R9: Every data register shifts one bit per rising edge in Shift-DR, from TDI toward bit 0, and bit 0 is presented on tdo. tdo changes only on falling edges. In the boundary register, bit i (for i from 0 to 7) is the cell for pin_in[i]/core_in[i], and bit 8+i is the cell for pin_out[i].
- R10: Shadow stages change only on a falling edge with the boundary register selected and the update strobe high, or in toggle mode in Run-Test/Idle. Shifting alone never moves pin_out or core_in.
- R11: Any code other than 4'h6, 4'h7 and 4'hA leaves the device in normal mode: core_in equals pin_in, pin_out equals core_out, and pin_oe is 1.
- R12: A low rst_n on a rising edge clears every register and shift stage. A low rst_n on a falling edge clears every shadow stage and tdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial test data in |
| ir_code | input | 4 | Current instruction code |
| st_capture | input | 1 | Controller is in Capture-DR |
| st_shift | input | 1 | Controller is in Shift-DR |
| st_update | input | 1 | Controller is in Update-DR |
| st_idle | input | 1 | Controller is in Run-Test/Idle |
| pin_in | input | 8 | Device input pins |
| core_out | input | 8 | Values from the core for the output pins |
| core_in | output | 8 | Values presented to the core |
| pin_out | output | 8 | Output pin data |
| pin_oe | output | 1 | Output pin enable, 1 drives |
| tdo | output | 1 | Serial test data out |

## Verification
The properties assume the instruction code and the state strobes change once per test-clock period, just after the rising edge, and hold through the following falling edge. They also assume at most one of capture, shift, update and idle is high at a time, as a real controller guarantees. The bench drives every input one time unit after a rising edge and samples after the falling edge. It asserts only one strobe per cycle and keeps reset low for several full periods before the first check.

// File: rtl/sbu_pkg.sv
// Shared definitions for the boundary scan unit: instruction codes and
// the decoded control bundle. Assumes a four-bit instruction register.
package sbu_pkg;
    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_FLOAT  = 4'h6;
    localparam logic [IR_W-1:0] OP_CLAMP  = 4'h7;
    localparam logic [IR_W-1:0] OP_READ   = 4'h8;
    localparam logic [IR_W-1:0] OP_SELF   = 4'h9;
    localparam logic [IR_W-1:0] OP_TOGGLE = 4'hA;
    localparam logic [IR_W-1:0] OP_CTRL   = 4'hB;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_BSR = 2'd1,
        PATH_CTL = 2'd2
    } path_e;

    typedef struct packed {
        path_e path;       // register between tdi and tdo
        logic  bsr_inv;    // boundary capture loads inverse
        logic  test_mode;  // core/pins fed from shadow stages
        logic  oe;         // output pins driven
        logic  toggle;     // output toggle in Run-Test/Idle
    } ctl_t;
endpackage

// File: rtl/sbu_decode.sv
// Instruction decoder. Maps the instruction code to the scan path
// choice, capture behaviour and pin/core mode. Purely combinational;
// assumes the code is stable for a whole test-clock period.
module sbu_decode
    import sbu_pkg::*;
(
    input  logic [IR_W-1:0] ir_code,
    output ctl_t            dec
);
    // Decode one code into the control bundle; unlisted codes act as bypass.
    always_comb begin
        dec           = '0;
        dec.path      = PATH_BYP;
        dec.oe        = 1'b1;
        unique case (ir_code)
            OP_FLOAT:  dec.oe = 1'b0;
            OP_CLAMP:  dec.test_mode = 1'b1;
            OP_READ:   dec.path = PATH_BSR;
            OP_SELF: begin
                dec.path    = PATH_BSR;
                dec.bsr_inv = 1'b1;
            end
            OP_TOGGLE: begin
                dec.test_mode = 1'b1;
                dec.toggle    = 1'b1;
            end
            OP_CTRL:   dec.path = PATH_CTL;
            default:   dec.path = PATH_BYP;
        endcase
    end
endmodule

// File: rtl/sbu_dr.sv
// Simple shift-only data register (bypass bit or control register).
// Shifts LSB-first on rising tck when selected in Shift-DR. In Capture-DR
// it either loads zero (CAP_ZERO=1) or keeps its contents.
module sbu_dr #(
    parameter int   W        = 1,
    parameter logic CAP_ZERO = 1'b0
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tdi,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    output logic so
);
    logic [W-1:0] q;
    logic [W-1:0] nxt;

    generate
        if (W == 1) begin : g_one
            assign nxt = tdi;
        end else begin : g_many
            assign nxt = {tdi, q[W-1:1]};
        end
    endgenerate

    // Capture or shift the register on the rising test clock.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            q <= '0;
        end else if (sel && capture) begin
            if (CAP_ZERO) q <= '0;
        end else if (sel && shift) begin
            q <= nxt;
        end
    end

    assign so = q[0];
endmodule

// File: rtl/sbu_bsr.sv
// Boundary register: N input cells (bits 0..N-1) then N output cells
// (bits N..2N-1). Shift stages act on rising tck, shadow stages load on
// falling tck. Assumes at most one state strobe is high at a time.
module sbu_bsr #(
    parameter int N = 8
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           tdi,
    input  logic           sel,
    input  logic           capture,
    input  logic           shift,
    input  logic           update,
    input  logic           idle,
    input  logic           invert,
    input  logic           toggle,
    output logic [2*N-1:0] shadow,
    output logic           so
);
    localparam int W = 2 * N;

    logic [W-1:0] stage;
    logic [W-1:0] chain_in;

    assign chain_in = {tdi, stage[W-1:1]};

    generate
        for (genvar i = 0; i < W; i++) begin : g_cell
            localparam logic CAN_TOG = (i >= N);
            logic st_q;
            logic sh_q;
            logic tog_en;

            assign tog_en = toggle && idle && CAN_TOG;

            // Shift stage: capture, shift or toggle on the rising edge.
            always_ff @(posedge tck) begin
                if (!rst_n) begin
                    st_q <= 1'b0;
                end else if (sel && capture) begin
                    if (invert) st_q <= ~st_q;
                end else if (sel && shift) begin
                    st_q <= chain_in[i];
                end else if (tog_en) begin
                    st_q <= ~st_q;
                end
            end

            // Shadow stage: load from the shift stage on the falling edge.
            always_ff @(negedge tck) begin
                if (!rst_n) begin
                    sh_q <= 1'b0;
                end else if ((sel && update) || tog_en) begin
                    sh_q <= st_q;
                end
            end

            assign stage[i]  = st_q;
            assign shadow[i] = sh_q;
        end
    endgenerate

    assign so = stage[0];
endmodule

// File: rtl/scan_boundary_unit.sv
// Top of the boundary scan unit. Decodes the instruction, hosts the
// bypass bit, control register and boundary register, muxes TDO on the
// falling edge and routes core/pin data. The TAP controller and the
// instruction register are outside; their state arrives as strobes.
module scan_boundary_unit
    import sbu_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int CTRL_W = 3
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              st_capture,
    input  logic              st_shift,
    input  logic              st_update,
    input  logic              st_idle,
    input  logic [N_BITS-1:0] pin_in,
    input  logic [N_BITS-1:0] core_out,
    output logic [N_BITS-1:0] core_in,
    output logic [N_BITS-1:0] pin_out,
    output logic              pin_oe,
    output logic              tdo
);
    localparam int BSR_W = 2 * N_BITS;

    ctl_t             dec;
    logic             sel_byp, sel_bsr, sel_ctl;
    logic             byp_so, ctl_so, bsr_so;
    logic [BSR_W-1:0] shadow;
    logic             tdo_q;

    sbu_decode u_dec (
        .ir_code (ir_code),
        .dec     (dec)
    );

    assign sel_byp = (dec.path == PATH_BYP);
    assign sel_bsr = (dec.path == PATH_BSR);
    assign sel_ctl = (dec.path == PATH_CTL);

    sbu_dr #(.W(1), .CAP_ZERO(1'b1)) u_byp (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .sel     (sel_byp),
        .capture (st_capture),
        .shift   (st_shift),
        .so      (byp_so)
    );

    sbu_dr #(.W(CTRL_W), .CAP_ZERO(1'b0)) u_ctl (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .sel     (sel_ctl),
        .capture (st_capture),
        .shift   (st_shift),
        .so      (ctl_so)
    );

    sbu_bsr #(.N(N_BITS)) u_bsr (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .sel     (sel_bsr),
        .capture (st_capture),
        .shift   (st_shift),
        .update  (st_update),
        .idle    (st_idle),
        .invert  (dec.bsr_inv),
        .toggle  (dec.toggle),
        .shadow  (shadow),
        .so      (bsr_so)
    );

    // Present the selected register's bit 0 on TDO at the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
        end else begin
            unique case (dec.path)
                PATH_BSR: tdo_q <= bsr_so;
                PATH_CTL: tdo_q <= ctl_so;
                default:  tdo_q <= byp_so;
            endcase
        end
    end

    // Route pin and core data either straight through or from the shadows.
    always_comb begin
        core_in = dec.test_mode ? shadow[N_BITS-1:0]     : pin_in;
        pin_out = dec.test_mode ? shadow[BSR_W-1:N_BITS] : core_out;
        pin_oe  = dec.oe;
    end

    assign tdo = tdo_q;
endmodule

// File: rtl/sbu_chk.sv
// Property checker for scan_boundary_unit, attached by bind. Assumes the
// code and strobes change only just after a rising edge.
module sbu_chk
    import sbu_pkg::*;
#(
    parameter int N_BITS = 8
) (
    input logic              tck,
    input logic              rst_n,
    input logic [IR_W-1:0]   ir_code,
    input logic              st_capture,
    input logic              st_idle,
    input logic [N_BITS-1:0] pin_in,
    input logic [N_BITS-1:0] core_out,
    input logic [N_BITS-1:0] core_in,
    input logic [N_BITS-1:0] pin_out,
    input logic              pin_oe,
    input logic              tdo
);
    logic on_byp, on_normal, tog_idle;

    assign on_byp    = (ir_code != OP_READ) && (ir_code != OP_SELF) && (ir_code != OP_CTRL);
    assign on_normal = (ir_code != OP_FLOAT) && (ir_code != OP_CLAMP) && (ir_code != OP_TOGGLE);
    assign tog_idle  = (ir_code == OP_TOGGLE) && st_idle;

    p_bypass_zero_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (st_capture && on_byp) |=> (!$stable(ir_code) || !tdo));

    p_float_off_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_code == OP_FLOAT) |-> (!pin_oe && core_in == pin_in));

    p_clamp_steady_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_code == OP_CLAMP && $past(ir_code) == OP_CLAMP) |-> ($stable(pin_out) && $stable(core_in)));

    p_toggle_flip_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (tog_idle && $past(tog_idle)) |-> (pin_out != $past(pin_out)));

    p_toggle_inputs_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_code == OP_TOGGLE && $past(ir_code) == OP_TOGGLE) |-> $stable(core_in));

    p_normal_mode_r11: assert property (@(posedge tck) disable iff (!rst_n)
        on_normal |-> (pin_oe && core_in == pin_in && pin_out == core_out));
endmodule

bind scan_boundary_unit sbu_chk #(.N_BITS(N_BITS)) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .ir_code    (ir_code),
    .st_capture (st_capture),
    .st_idle    (st_idle),
    .pin_in     (pin_in),
    .core_out   (core_out),
    .core_in    (core_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .tdo        (tdo)
);

// File: tb/scan_boundary_unit_tb.sv
module scan_boundary_unit_tb;
    logic       tck = 1'b0;
    logic       rst_n, tdi, st_capture, st_shift, st_update, st_idle;
    logic [3:0] ir_code;
    logic [7:0] pin_in, core_out, core_in, pin_out;
    logic       pin_oe, tdo;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #5 tck = ~tck;

    scan_boundary_unit u_dut (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .ir_code(ir_code),
        .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
        .st_idle(st_idle), .pin_in(pin_in), .core_out(core_out),
        .core_in(core_in), .pin_out(pin_out), .pin_oe(pin_oe), .tdo(tdo)
    );

    // {code, pin_in, core_out, exp core_in, exp pin_out, exp oe}
    // shadows hold input 8'hA5, output 8'h3C when walked
    localparam logic [36:0] VEC [10] = '{
        {4'hF, 8'h11, 8'h22, 8'h11, 8'h22, 1'b1},  // R11 bypass normal
        {4'h6, 8'h33, 8'h44, 8'h33, 8'h44, 1'b0},  // R2 float
        {4'h7, 8'h55, 8'h66, 8'hA5, 8'h3C, 1'b1},  // R3 clamp
        {4'h8, 8'h77, 8'h88, 8'h77, 8'h88, 1'b1},  // R4 read normal
        {4'h9, 8'h99, 8'hAA, 8'h99, 8'hAA, 1'b1},  // R5 self-test normal
        {4'hB, 8'hBB, 8'hCC, 8'hBB, 8'hCC, 1'b1},  // R8 ctrl normal
        {4'h0, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 1'b1},  // R11 unknown
        {4'h3, 8'hC3, 8'h5A, 8'hC3, 8'h5A, 1'b1},  // R11 unknown
        {4'hA, 8'hEE, 8'h11, 8'hA5, 8'h3C, 1'b1},  // R7 toggle, not idle
        {4'h6, 8'h01, 8'h80, 8'h01, 8'h80, 1'b0}   // R2 float
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        #1;
    endtask

    // One DR pass: capture, n shift cycles, optional update.
    task automatic scan(input logic [3:0] ir, input int n, input logic [15:0] din,
                        input bit upd, output logic [15:0] dout);
        dout = '0;
        ir_code = ir;
        cyc();
        st_capture = 1'b1;
        cyc();
        st_capture = 1'b0;
        for (int k = 0; k < n; k++) begin
            st_shift = 1'b1;
            tdi = din[k];
            #6;
            dout[k] = tdo;
            cyc();
        end
        st_shift = 1'b0;
        st_update = upd;
        cyc();
        st_update = 1'b0;
        cyc();
    endtask

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; tdi = 1'b0; ir_code = 4'h7;
        st_capture = 0; st_shift = 0; st_update = 0; st_idle = 0;
        pin_in = 8'h5A; core_out = 8'hA5;
        repeat (4) cyc();
        #6;
        check("R12 reset core_in", core_in, 8'h00);
        check("R12 reset pin_out", pin_out, 8'h00);
        check("R12 reset tdo", tdo, 1'b0);
        cyc();
        rst_n = 1'b1;
        cyc();

        // R1 bypass captures 0, then tdi follows
        scan(4'hF, 2, 16'h0003, 0, d);
        check("R1 bypass capture/shift", d[1:0], 2'b10);
        scan(4'h6, 1, 16'h0001, 0, d);
        check("R1 float bypass captures 0", d[0], 1'b0);

        // R9 tdo changes on the falling edge only
        ir_code = 4'hF;
        cyc();
        st_capture = 1'b1; cyc(); st_capture = 1'b0;
        st_shift = 1'b1; tdi = 1'b1; cyc();
        check("R9 tdo held before falling edge", tdo, 1'b0);
        #5;
        check("R9 tdo after falling edge", tdo, 1'b1);
        st_shift = 1'b0;
        cyc();

        // R8 control register hold on capture
        scan(4'hB, 3, 16'h0005, 0, d);
        check("R8 ctrl reset content", d[2:0], 3'b000);
        scan(4'hB, 3, 16'h0000, 0, d);
        check("R8 ctrl capture holds", d[2:0], 3'b101);

        // R4/R9 load boundary: out cells 3C, in cells A5
        scan(4'h8, 16, 16'h3CA5, 1, d);
        check("R12 boundary reset content", d, 16'h0000);
        scan(4'h8, 16, 16'h0000, 0, d);
        check("R4 read capture holds", d, 16'h3CA5);
        // R5 self-test inverts zeros
        scan(4'h9, 16, 16'h1234, 0, d);
        check("R5 self-test inverts", d, 16'hFFFF);
        scan(4'h8, 16, 16'h3CA5, 0, d);
        check("R4 read after self-test", d, 16'h1234);

        // Table walk; shadows untouched by non-update scans (R10)
        foreach (VEC[i]) begin
            ir_code = VEC[i][36:33];
            pin_in = VEC[i][32:25];
            core_out = VEC[i][24:17];
            #6;
            check($sformatf("R2/R3/R10/R11 vec%0d core_in", i), core_in, VEC[i][16:9]);
            check($sformatf("R2/R3/R10/R11 vec%0d pin_out", i), pin_out, VEC[i][8:1]);
            check($sformatf("R2/R3/R11 vec%0d oe", i), pin_oe, VEC[i][0]);
            cyc();
        end

        // R6/R7 toggle in Run-Test/Idle
        ir_code = 4'hA; pin_in = 8'h00;
        cyc();
        st_idle = 1'b1;
        for (int k = 0; k < 4; k++) begin
            pin_in = 8'(k * 37);
            #6;
            check($sformatf("R6 toggle pin_out step%0d", k), pin_out, (k % 2) ? 8'hC3 : 8'h3C);
            check($sformatf("R7 toggle core_in step%0d", k), core_in, 8'hA5);
            cyc();
        end
        st_idle = 1'b0;
        #6;
        check("R6 shadow after toggling", pin_out, 8'hC3);
        cyc();
        scan(4'h8, 16, 16'h0000, 0, d);
        check("R6/R7 stages after toggling", d, 16'h3CA5);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule